// File: doc/BRIEF.md
# SDRAM Burst Command Sequencer

This block sits on the controller side of a two-bank synchronous DRAM with a 16-bit data bus and 8-bit column addresses. It accepts single requests (open a row, read, write, each column access optionally with auto-precharge). It turns each accepted request into one registered command on the row strobe, column strobe, write-enable and address pins. A NOP goes out on every cycle that carries no command. A request waits behind a valid/ready handshake until the bank's row-to-column delay and any pending auto-precharge lockout have expired.

Write data is streamed without a gap. The word present on `wr_data` in the cycle a WRITE is accepted appears on the data bus together with the WRITE command. Each later word follows on the next edge, and `wr_take` tells the user which cycles consume a word. The burst length is a parameter, or the block is built for full-page operation, where a write burst runs until the next READ or WRITE and the tracked column wraps. A new WRITE may cut a running burst short on any cycle. A READ ends it and releases the bus. Initialization, refresh, mode-register setup and read-data capture are handled elsewhere.

Top module: `sdram_burst_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the command pins show NOP (`{sd_ras_n,sd_cas_n,sd_we_n}` = 3'b111) and `sd_dq_oe` is low. With no timing window running, `req_ready` is high.
- R2: An accepted request with `req_op` = 2'b00 (activate) puts 3'b011 on `{sd_ras_n,sd_cas_n,sd_we_n}` in the following cycle. In that cycle `sd_addr[10:0]` carries the row and `sd_addr[11]` the bank.
- R3: An accepted read (`req_op` = 2'b01) drives 3'b101 in the next cycle, and an accepted write (`req_op` = 2'b10) drives 3'b100. In both cases `sd_addr[7:0]` is the column, `sd_addr[11]` the bank, `sd_addr[10]` the auto-precharge flag and `sd_addr[9:8]` zero.
- R4: A read or write to bank b is not accepted earlier than T_RCD cycles after the activate of bank b was accepted. `req_ready` stays low for it until then. Activates, and column requests to the other bank, are not held by that window.
- R5: In the cycle a write is accepted, `wr_take` is high. In the next cycle the WRITE command, `sd_dq_oe` high, `sd_dq_out` equal to the `wr_data` of the accept cycle, and `burst_col` equal to the requested column all appear together.
- R6: With a fixed burst length BL (a power of two), the bus carries BL consecutive words and then `sd_dq_oe` falls. Each word is the `wr_data` of a cycle in which `wr_take` was high. `burst_col` steps by one in its low log2(BL) bits only, wrapping inside the aligned group.
- R7: In full-page mode a write burst keeps streaming until a read or write is accepted. `burst_col` steps from 255 back to 0.
- R8: A write accepted while a burst is streaming replaces it from the next cycle: new column, new data, new length count.
- R9: In fixed-length mode, after a read or write with auto-precharge is accepted, no request of any kind is accepted for T_RP + BL cycles. The next command is therefore at least that many cycles later.
- R10: In full-page mode the auto-precharge flag is dropped: `sd_addr[10]` is 0 on reads and writes, and no lockout follows.
- R11: Every cycle that follows a cycle with no accepted request shows NOP on the command pins.
- R12: An accepted read ends a running write burst: `sd_dq_oe` is low in the cycle the READ is on the pins. An activate accepted during a burst leaves the burst running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The offered request is taken on this edge |
| req_op | input | 2 | 00 activate, 01 read, 10 write, 11 no operation |
| req_autopre | input | 1 | Close the row after the column access |
| req_bank | input | 1 | Target bank |
| req_row | input | 11 | Row for an activate |
| req_col | input | 8 | Column for a read or write |
| wr_data | input | 16 | Write word offered for the current cycle |
| wr_take | output | 1 | The word on wr_data is consumed on this edge |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address: bank on bit 11, auto-precharge on bit 10 |
| sd_dq_out | output | 16 | Write data driven to the memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| burst_col | output | 8 | Column of the word now on sd_dq_out |

## Verification
The case that matters most is a new column command landing in a cycle where a write burst is still streaming. A WRITE there must restart the data stream on that same edge, and a READ must silence the bus on that same edge. The bench provokes this by issuing a second write after zero to four idle cycles, by a read one cycle into a burst, and by a random request stream with short gaps. A cycle-by-cycle model built from the rules judges the result. It predicts the command, the bus enable, the data word, the column and `wr_take` for every cycle. It also predicts `req_ready` from the cycle numbers of the last activate and the last auto-precharge, so a timing window that opens one cycle early or late is reported.

// File: rtl/sdseq_pkg.sv
// Shared encodings for the SDRAM burst sequencer.
// Assumes a single bank-select bit and the usual three active-low strobes.
package sdseq_pkg;

    typedef enum logic [1:0] {
        OP_ACT   = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_NONE  = 2'b11
    } seq_op_e;

    // {ras_n, cas_n, we_n}
    localparam logic [2:0] PIN_NOP   = 3'b111;
    localparam logic [2:0] PIN_ACT   = 3'b011;
    localparam logic [2:0] PIN_READ  = 3'b101;
    localparam logic [2:0] PIN_WRITE = 3'b100;

endpackage

// File: rtl/sdseq_countdown.sv
// Loadable down-counter used for every timing window of the sequencer.
// Loading N keeps busy high for N cycles after the load edge; a new load
// restarts the window. Assumes load_val fits CNT_W.
module sdseq_countdown #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] cnt_q;

    // Count the window down to zero, restarting on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R4 and R9: a nonzero load opens a window on the next cycle.
    a_r4_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> busy);

    // R4 and R9: a closed window stays closed until reloaded.
    a_r9_window_stays_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> !busy);

endmodule

// File: rtl/sdseq_wburst.sv
// Write-burst engine: registers one data word per cycle onto the bus,
// starting on the edge that also registers the WRITE command, and tracks
// the column of the word being driven. Fixed bursts wrap inside their
// aligned group; full-page bursts wrap over the whole row and run until
// stopped. Assumes BURST_LEN is a power of two.
module sdseq_wburst #(
    parameter int DATA_W    = 16,
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4,
    parameter bit FULL_PAGE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [COL_W-1:0]  start_col,
    input  logic [DATA_W-1:0] wr_data,
    output logic              take,
    output logic [DATA_W-1:0] dq,
    output logic              oe,
    output logic [COL_W-1:0]  col
);

    localparam int REM_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [COL_W-1:0] WRAP_MASK =
        FULL_PAGE ? {COL_W{1'b1}} : COL_W'(BURST_LEN - 1);
    localparam bit MULTI = FULL_PAGE || (BURST_LEN > 1);

    logic [REM_W-1:0] rem_q;
    logic             run_q;
    logic [COL_W-1:0] col_step;

    // Next column: low bits advance under the wrap mask, high bits hold.
    assign col_step = (col & ~WRAP_MASK) | ((col + 1'b1) & WRAP_MASK);

    // A word is consumed when a burst starts or keeps streaming.
    assign take = start || (run_q && !stop);

    // Burst sequencing: start, stop, advance or release the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            run_q <= 1'b0;
            oe    <= 1'b0;
            dq    <= '0;
            col   <= '0;
        end else if (start) begin
            dq    <= wr_data;
            oe    <= 1'b1;
            col   <= start_col;
            rem_q <= REM_W'(BURST_LEN - 1);
            run_q <= MULTI;
        end else if (stop) begin
            oe    <= 1'b0;
            run_q <= 1'b0;
            rem_q <= '0;
        end else if (run_q) begin
            dq  <= wr_data;
            oe  <= 1'b1;
            col <= col_step;
            if (!FULL_PAGE) begin
                rem_q <= rem_q - 1'b1;
                run_q <= (rem_q > REM_W'(1));
            end
        end else begin
            oe <= 1'b0;
        end
    end

    // R5: the first word and its column follow the start edge.
    a_r5_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (oe && dq == $past(wr_data) && col == $past(start_col)));

    // R12: a stop without a restart releases the bus.
    a_r12_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop && !start) |-> !oe);

    // R7: in full-page mode a streaming word lands one column further on.
    if (FULL_PAGE) begin : g_fp_chk
        a_r7_column_steps: assert property (@(posedge clk) disable iff (!rst_n)
            $past(run_q && !start && !stop) |-> (oe && col == COL_W'($past(col) + 1'b1)));
    end

endmodule

// File: rtl/sdram_burst_seq.sv
// SDRAM burst command sequencer (top). Accepts one request per cycle over a
// valid/ready handshake, registers the matching command onto the SDRAM pins
// and streams write data through sdseq_wburst. Per-bank activate-to-column
// windows and the auto-precharge lockout come from sdseq_countdown.
// Assumes: two banks, bank select above the row bits, the auto-precharge
// bit at address bit 10, COL_W <= 10 < ROW_W, T_RCD >= 1, T_RP >= 1.
module sdram_burst_seq
    import sdseq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int COL_W     = 8,
    parameter int ROW_W     = 11,
    parameter int BURST_LEN = 4,
    parameter bit FULL_PAGE = 1'b0,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic              req_autopre,
    input  logic              req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_take,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ROW_W:0]    sd_addr,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    output logic [COL_W-1:0]  burst_col
);

    localparam int NBANK    = 2;
    localparam int ADDR_W   = ROW_W + 1;
    localparam int AP_BIT   = 10;
    localparam int LOCK_LEN = T_RP + BURST_LEN;
    localparam int MAX_WIN  = (LOCK_LEN > T_RCD) ? LOCK_LEN : T_RCD;
    localparam int CNT_W    = $clog2(MAX_WIN + 1);

    seq_op_e           op;
    logic              is_col;
    logic              ap_eff;
    logic              accept;
    logic              lock_busy;
    logic [NBANK-1:0]  rcd_busy;
    logic [ADDR_W-1:0] col_addr;
    logic [2:0]        pins_q;

    assign op     = seq_op_e'(req_op);
    assign is_col = (op == OP_READ) || (op == OP_WRITE);
    assign ap_eff = is_col && req_autopre && !FULL_PAGE;

    // Handshake: blocked by the lockout, or by the target bank's tRCD window.
    assign req_ready = rst_n && !lock_busy && !(is_col && rcd_busy[req_bank]);
    assign accept    = req_valid && req_ready;

    // One activate-to-column window per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sdseq_countdown #(.CNT_W(CNT_W)) rcd_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept && op == OP_ACT && req_bank == 1'(b)),
            .load_val (CNT_W'(T_RCD - 1)),
            .busy     (rcd_busy[b])
        );
    end

    // Lockout after a column access with auto-precharge.
    sdseq_countdown #(.CNT_W(CNT_W)) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && ap_eff),
        .load_val (CNT_W'(LOCK_LEN - 1)),
        .busy     (lock_busy)
    );

    // Column-command address: bank on top, precharge flag, column at the bottom.
    always_comb begin
        col_addr                = '0;
        col_addr[COL_W-1:0]     = req_col;
        col_addr[AP_BIT]        = ap_eff;
        col_addr[ADDR_W-1]      = req_bank;
    end

    // Command register: one command per accepted request, NOP otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q  <= PIN_NOP;
            sd_addr <= '0;
        end else if (accept) begin
            unique case (op)
                OP_ACT: begin
                    pins_q  <= PIN_ACT;
                    sd_addr <= {req_bank, req_row};
                end
                OP_READ: begin
                    pins_q  <= PIN_READ;
                    sd_addr <= col_addr;
                end
                OP_WRITE: begin
                    pins_q  <= PIN_WRITE;
                    sd_addr <= col_addr;
                end
                default: pins_q <= PIN_NOP;
            endcase
        end else begin
            pins_q <= PIN_NOP;
        end
    end

    assign {sd_ras_n, sd_cas_n, sd_we_n} = pins_q;

    sdseq_wburst #(
        .DATA_W    (DATA_W),
        .COL_W     (COL_W),
        .BURST_LEN (BURST_LEN),
        .FULL_PAGE (FULL_PAGE)
    ) wburst_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept && op == OP_WRITE),
        .stop      (accept && op == OP_READ),
        .start_col (req_col),
        .wr_data   (wr_data),
        .take      (wr_take),
        .dq        (sd_dq_out),
        .oe        (sd_dq_oe),
        .col       (burst_col)
    );

    // R11: a cycle without an accepted request leaves NOP on the pins.
    a_r11_idle_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(accept) |-> ({sd_ras_n, sd_cas_n, sd_we_n} == PIN_NOP));

    // R9: an auto-precharge access shuts the handshake on the next cycle.
    a_r9_lockout_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ap_eff) |=> !req_ready);

    // R4: a column request to a just-opened bank is held for at least a cycle.
    if (T_RCD > 1) begin : g_rcd_chk
        a_r4_rcd_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && op == OP_ACT) |=>
                !(is_col && req_bank == $past(req_bank) && req_ready));
    end

    // R10: full-page builds never raise the precharge bit on a column command.
    if (FULL_PAGE) begin : g_fp_ap_chk
        a_r10_no_autopre: assert property (@(posedge clk) disable iff (!rst_n)
            !sd_cas_n |-> !sd_addr[AP_BIT]);
    end

    // R3: the precharge bit follows the request of the previous cycle.
    a_r3_ap_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $past(accept && is_col) |-> (sd_addr[AP_BIT] == $past(req_autopre && !FULL_PAGE)));

endmodule

// File: tb/sdram_burst_seq_tb_top.sv
`timescale 1ns/1ps

// Cycle model of the sequencer built from the requirements; compares every
// cycle and counts checks and miscompares.
module sdseq_scoreboard #(
    parameter int BL    = 4,
    parameter bit FP    = 1'b0,
    parameter int T_RCD = 2,
    parameter int T_RP  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic        req_autopre,
    input  logic        req_bank,
    input  logic [10:0] req_row,
    input  logic [7:0]  req_col,
    input  logic [15:0] wr_data,
    input  logic        req_ready,
    input  logic        wr_take,
    input  logic [2:0]  pins,
    input  logic [11:0] addr,
    input  logic [15:0] dq,
    input  logic        oe,
    input  logic [7:0]  col,
    output int          n_chk,
    output int          n_bad
);
    int          cyc;
    int          act_at [2];
    int          lock_until;
    int          left;
    bit          run, moe, chk_addr, is_col, acc, e_rdy, e_take, apx;
    logic [7:0]  mcol, mask;
    logic [15:0] mdq;
    logic [2:0]  ecmd;
    logic [11:0] eaddr;
    string       ctag, btag;

    initial begin
        n_chk = 0;
        n_bad = 0;
    end

    task automatic cmp(string tag, string what, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; act_at[0] = -1000; act_at[1] = -1000; lock_until = 0;
            run = 0; moe = 0; left = 0;
            #1;
            cmp("R1", "cmd", pins, 3'b111);
            cmp("R1", "oe", oe, 0);
        end else begin
            mask   = FP ? 8'hFF : 8'(BL - 1);
            is_col = (req_op == 2'b01) || (req_op == 2'b10);
            e_rdy  = (cyc >= lock_until) && (!is_col || cyc >= act_at[req_bank] + T_RCD);
            if (req_valid)
                cmp((is_col && cyc >= lock_until) ? "R4" : "R9", "ready", req_ready, e_rdy);
            acc    = req_valid && req_ready;
            e_take = (acc && req_op == 2'b10) || (run && !(acc && req_op == 2'b01));
            cmp("R5", "wr_take", wr_take, e_take);
            apx = req_autopre && !FP;
            chk_addr = 0;
            ecmd = 3'b111; ctag = "R11";
            if (acc) begin
                case (req_op)
                    2'b00: begin
                        ecmd = 3'b011; ctag = "R2"; chk_addr = 1;
                        eaddr = {req_bank, req_row};
                        act_at[req_bank] = cyc;
                    end
                    2'b01, 2'b10: begin
                        ecmd = (req_op == 2'b01) ? 3'b101 : 3'b100;
                        ctag = FP ? "R10" : "R3"; chk_addr = 1;
                        eaddr = {req_bank, apx, 2'b00, req_col};
                        if (apx) lock_until = cyc + T_RP + BL;
                    end
                    default: ;
                endcase
            end
            if (acc && req_op == 2'b10) begin
                btag = run ? "R8" : "R5";
                mcol = req_col; mdq = wr_data; moe = 1;
                left = BL - 1; run = FP || (BL > 1);
            end else if (acc && req_op == 2'b01) begin
                btag = "R12"; moe = 0; run = 0;
            end else if (run) begin
                btag = FP ? "R7" : "R6";
                mcol = (mcol & ~mask) | (8'(mcol + 1) & mask);
                mdq = wr_data; moe = 1;
                if (!FP) begin left--; run = (left > 0); end
            end else begin
                btag = "R6"; moe = 0;
            end
            cyc++;
            #1;
            cmp(ctag, "cmd", pins, ecmd);
            if (chk_addr) cmp(ctag, "addr", addr, eaddr);
            cmp(btag, "oe", oe, moe);
            if (moe) begin
                cmp(btag, "dq", dq, mdq);
                cmp(btag, "col", col, mcol);
            end
        end
    end
endmodule

module sdram_burst_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v [2];
    logic [1:0]  op [2];
    logic        ap [2];
    logic        bk [2];
    logic [10:0] row [2];
    logic [7:0]  colr [2];
    logic [15:0] wd [2];
    logic        rdy [2];
    logic        take [2];
    logic        ras [2], cas [2], we [2], oe [2];
    logic [11:0] addr [2];
    logic [15:0] dq [2];
    logic [7:0]  bcol [2];
    int          chk [2], bad [2];
    int          own_chk = 0, own_bad = 0, wd_cnt = 0, tick = 0;
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    sdram_burst_seq #(.BURST_LEN(4), .FULL_PAGE(1'b0), .T_RCD(2), .T_RP(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(v[0]), .req_ready(rdy[0]), .req_op(op[0]),
        .req_autopre(ap[0]), .req_bank(bk[0]), .req_row(row[0]), .req_col(colr[0]),
        .wr_data(wd[0]), .wr_take(take[0]), .sd_ras_n(ras[0]), .sd_cas_n(cas[0]),
        .sd_we_n(we[0]), .sd_addr(addr[0]), .sd_dq_out(dq[0]), .sd_dq_oe(oe[0]),
        .burst_col(bcol[0]));

    sdram_burst_seq #(.BURST_LEN(8), .FULL_PAGE(1'b1), .T_RCD(3), .T_RP(2)) dut_fp_i (
        .clk(clk), .rst_n(rst_n), .req_valid(v[1]), .req_ready(rdy[1]), .req_op(op[1]),
        .req_autopre(ap[1]), .req_bank(bk[1]), .req_row(row[1]), .req_col(colr[1]),
        .wr_data(wd[1]), .wr_take(take[1]), .sd_ras_n(ras[1]), .sd_cas_n(cas[1]),
        .sd_we_n(we[1]), .sd_addr(addr[1]), .sd_dq_out(dq[1]), .sd_dq_oe(oe[1]),
        .burst_col(bcol[1]));

    sdseq_scoreboard #(.BL(4), .FP(1'b0), .T_RCD(2), .T_RP(2)) sb0 (
        .clk(clk), .rst_n(rst_n), .req_valid(v[0]), .req_op(op[0]), .req_autopre(ap[0]),
        .req_bank(bk[0]), .req_row(row[0]), .req_col(colr[0]), .wr_data(wd[0]),
        .req_ready(rdy[0]), .wr_take(take[0]), .pins({ras[0], cas[0], we[0]}),
        .addr(addr[0]), .dq(dq[0]), .oe(oe[0]), .col(bcol[0]), .n_chk(chk[0]), .n_bad(bad[0]));

    sdseq_scoreboard #(.BL(8), .FP(1'b1), .T_RCD(3), .T_RP(2)) sb1 (
        .clk(clk), .rst_n(rst_n), .req_valid(v[1]), .req_op(op[1]), .req_autopre(ap[1]),
        .req_bank(bk[1]), .req_row(row[1]), .req_col(colr[1]), .wr_data(wd[1]),
        .req_ready(rdy[1]), .wr_take(take[1]), .pins({ras[1], cas[1], we[1]}),
        .addr(addr[1]), .dq(dq[1]), .oe(oe[1]), .col(bcol[1]), .n_chk(chk[1]), .n_bad(bad[1]));

    // Fresh write word every cycle, changed away from the active edge.
    always @(negedge clk) begin
        tick <= tick + 1;
        wd[0] <= 16'(tick * 16'h9E37 + 16'h0101);
        wd[1] <= 16'(tick * 16'h6B43 + 16'h5A00);
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==",
                 chk[0] + chk[1] + own_chk, bad[0] + bad[1] + own_bad);
        $finish;
    endtask

    // Watchdog: a hung handshake counts as a failure.
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 150000) begin
            own_chk++; own_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", wd_cnt);
            report();
        end
    end

    task automatic issue(int d, int o, bit a, bit b, int r, int c);
        @(negedge clk);
        v[d] = 1'b1; op[d] = 2'(o); ap[d] = a; bk[d] = b; row[d] = 11'(r); colr[d] = 8'(c);
        #1;
        while (!rdy[d]) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle(int d, int n);
        @(negedge clk);
        v[d] = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    task automatic rand_run(int d, int n);
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(d, (lf[1:0] == 2'b11) ? 2 : int'(lf[1:0]), lf[4] & lf[5], lf[6],
                  int'(lf[15:5]), int'(lf[14:7]));
            if (lf[9:8] != 2'b00) idle(d, int'(lf[9:8]));
        end
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            v[d] = 0; op[d] = 0; ap[d] = 0; bk[d] = 0; row[d] = 0; colr[d] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: ready is high straight after reset.
        for (int d = 0; d < 2; d++) begin
            own_chk++;
            if (rdy[d] !== 1'b1) begin
                own_bad++;
                $display("FAIL R1 ready after reset: got %b expected 1", rdy[d]);
            end
        end

        // Fixed-burst build: R2, R4, R5, R6 on both banks.
        for (int b = 0; b < 2; b++) begin
            issue(0, 0, 0, b, 11'h5A5 ^ b, 0);
            issue(0, 2, 0, b, 0, 8'h10 * b + 3);
            idle(0, 6);
        end
        // R8: second write after 0..4 idle cycles.
        for (int k = 0; k < 5; k++) begin
            issue(0, 2, 0, 0, 0, 8'h40 + k);
            if (k > 0) idle(0, k);
            issue(0, 2, 0, 0, 0, 8'h81 + k);
            idle(0, 6);
        end
        // R9: lockout after auto-precharge read and write.
        issue(0, 1, 1, 1, 0, 5);
        issue(0, 0, 0, 0, 3, 0);
        idle(0, 2);
        issue(0, 2, 1, 0, 0, 9);
        issue(0, 2, 0, 0, 0, 8'h20);
        idle(0, 6);
        // R12: read cuts a burst, activate does not.
        issue(0, 2, 0, 1, 0, 8'hF0);
        idle(0, 1);
        issue(0, 1, 0, 1, 0, 8'h33);
        idle(0, 4);
        issue(0, 2, 0, 0, 0, 8'h7E);
        issue(0, 0, 0, 1, 7, 0);
        idle(0, 6);
        rand_run(0, 400);
        idle(0, 8);

        // Full-page build: R7 wrap, R8, R10, R12.
        issue(1, 0, 0, 0, 1, 0);
        issue(1, 2, 0, 0, 0, 8'hFA);
        idle(1, 12);
        issue(1, 2, 0, 0, 0, 8'h10);
        idle(1, 3);
        issue(1, 1, 1, 0, 0, 8'h20);
        issue(1, 0, 0, 1, 5, 0);
        issue(1, 2, 1, 1, 0, 8'hFF);
        idle(1, 300);
        issue(1, 1, 0, 1, 0, 0);
        idle(1, 3);
        rand_run(1, 200);
        idle(1, 8);
        report();
    end
endmodule